// File: doc/BRIEF.md
# Streaming Bilinear Pixel Interpolator

This block enlarges an RGB image by bilinear interpolation while the source pixels stream past. Each output pixel is a weighted blend of four neighbouring source pixels. An upstream address generator presents those four neighbours on consecutive input beats, always in the same order. Because that order and the fractional weights depend only on the image size and the enlargement factor, the weights are not computed at run time. They come from a table that is built from the `SCALE` parameter when the design elaborates.

The block runs on a single clock. A `beat_en` strobe, high on every second cycle, marks the input beat rate. The arithmetic therefore has two clocks per beat and eight clocks per output pixel. Four input beats gather one group. A shared datapath, driven by the states IDLE, LOAD, ROW_R, ROW_G, ROW_B, COL_R, COL_G, COL_B and PACK, works on the finished group while the gatherer collects the next one.

The transitions are:
- IDLE goes to LOAD when a group completes.
- LOAD, ROW_R, ROW_G, ROW_B, COL_R, COL_G and COL_B each step unconditionally to the next state, in that order.
- PACK goes back to LOAD if another group has just completed, and to IDLE otherwise.

Top module: `bli_interp`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `out_pix` is 0.
- R2: An input beat is taken only on a cycle where both `beat_en` and `in_valid` are 1. On any other cycle, the values on `in_pix` and `in_sof` change no later output.
- R3: Four taken beats form one group. Their neighbour order is upper-left, upper-right, lower-left, lower-right.
- R4: Pixels are packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each channel is blended separately and repacked into the same positions.
- R5: Each channel result is ((UL·(256−fx)+UR·fx)·(256−fy)+(LL·(256−fx)+LR·fx)·fy) >> 16, truncated. fx and fy are 8-bit fractions.
- R6: Weight entry k holds fx = ((k mod SCALE)·256)/SCALE and fy = ((k div SCALE)·256)/SCALE. Each completed group uses the current entry and then advances the pointer. After entry SCALE·SCALE−1 the pointer wraps to 0.
- R7: A taken beat with `in_sof` = 1 becomes the upper-left pixel of a new group and resets the weight pointer to entry 0. Any partly gathered group is discarded.
- R8: `out_valid` is 1 for exactly one clock. That clock follows the ninth rising edge after the edge that took the group's fourth beat.
- R9: Groups arriving back to back (one every four beats) each produce one output. The outputs are eight clocks apart and none is lost.
- R10: `out_pix` holds its last value while `out_valid` is 0.
- R11: Once input stops, the last group still drains to the output, and no further output follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, twice the beat rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_en | input | 1 | Beat strobe, high on every second cycle |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame |
| in_pix | input | 24 | Packed source pixel |
| out_valid | output | 1 | One-clock output pulse |
| out_pix | output | 24 | Packed interpolated pixel |

## Verification
Two functions share a cycle when streaming is continuous. On that clock the sequencer is in PACK, emitting the previous result, while the gatherer signals a newly completed group, so PACK must go straight to LOAD. The bench provokes this with uninterrupted runs of groups, including a run that wraps the weight table. Its queue-based reference model demands an output pulse exactly eight clocks after the previous one, carrying the correct pixel. A missed handover shows up as a missing or late pulse.

// File: rtl/bli_pkg.sv
package bli_pkg;
    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;
    localparam int WGT_W  = 8;
    localparam int ROW_W  = CH_W + WGT_W;
    localparam int COL_W  = ROW_W + WGT_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ROW_R,
        ST_ROW_G,
        ST_ROW_B,
        ST_COL_R,
        ST_COL_G,
        ST_COL_B,
        ST_PACK
    } seq_state_t;
endpackage

// File: rtl/bli_weight_rom.sv
module bli_weight_rom #(
    parameter int SCALE = 4,
    parameter int WGT_W = 8,
    localparam int DEPTH = SCALE * SCALE,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [WGT_W-1:0] fx,
    output logic [WGT_W-1:0] fy
);
    localparam int ONE = 1 << WGT_W;

    logic [WGT_W-1:0] tbl_fx [DEPTH];
    logic [WGT_W-1:0] tbl_fy [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign tbl_fx[k] = WGT_W'(((k % SCALE) * ONE) / SCALE);
        assign tbl_fy[k] = WGT_W'(((k / SCALE) * ONE) / SCALE);
    end

    assign fx = tbl_fx[idx];
    assign fy = tbl_fy[idx];
endmodule

// File: rtl/bli_gather.sv
module bli_gather #(
    parameter int SCALE = 4,
    parameter int PIX_W = 24,
    parameter int WGT_W = 8,
    localparam int DEPTH = SCALE * SCALE,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_en,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic [PIX_W-1:0] grp_ul,
    output logic [PIX_W-1:0] grp_ur,
    output logic [PIX_W-1:0] grp_ll,
    output logic [PIX_W-1:0] grp_lr,
    output logic [WGT_W-1:0] grp_fx,
    output logic [WGT_W-1:0] grp_fy,
    output logic             grp_stb,
    output logic [1:0]       beat_cnt,
    output logic [IDX_W-1:0] wptr
);
    logic [PIX_W-1:0] hold [4];
    logic [WGT_W-1:0] rom_fx;
    logic [WGT_W-1:0] rom_fy;
    logic             take;

    assign take = beat_en && in_valid;

    bli_weight_rom #(.SCALE(SCALE), .WGT_W(WGT_W)) rom_i (
        .idx (wptr),
        .fx  (rom_fx),
        .fy  (rom_fy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
            wptr     <= '0;
            grp_stb  <= 1'b0;
            grp_ul   <= '0;
            grp_ur   <= '0;
            grp_ll   <= '0;
            grp_lr   <= '0;
            grp_fx   <= '0;
            grp_fy   <= '0;
            for (int i = 0; i < 4; i++) hold[i] <= '0;
        end else begin
            grp_stb <= 1'b0;
            if (take) begin
                if (in_sof) begin
                    hold[0]  <= in_pix;
                    beat_cnt <= 2'd1;
                    wptr     <= '0;
                end else if (beat_cnt == 2'd3) begin
                    grp_ul   <= hold[0];
                    grp_ur   <= hold[1];
                    grp_ll   <= hold[2];
                    grp_lr   <= in_pix;
                    grp_fx   <= rom_fx;
                    grp_fy   <= rom_fy;
                    grp_stb  <= 1'b1;
                    beat_cnt <= 2'd0;
                    wptr     <= (wptr == IDX_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
                end else begin
                    hold[beat_cnt] <= in_pix;
                    beat_cnt       <= beat_cnt + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/bli_lerp.sv
module bli_lerp #(
    parameter int IN_W = 8,
    parameter int F_W  = 8,
    localparam int OUT_W = IN_W + F_W
) (
    input  logic [IN_W-1:0]  a,
    input  logic [IN_W-1:0]  b,
    input  logic [F_W-1:0]   f,
    output logic [OUT_W-1:0] y
);
    localparam int SW = OUT_W + 1;

    logic [SW-1:0] ea, eb, wa, wb, sum;

    always_comb begin
        ea  = SW'(a);
        eb  = SW'(b);
        wb  = SW'(f);
        wa  = SW'(1 << F_W) - wb;
        sum = ea * wa + eb * wb;
        y   = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/bli_interp.sv
module bli_interp #(
    parameter int SCALE = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat_en,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [23:0] in_pix,
    output logic        out_valid,
    output logic [23:0] out_pix
);
    import bli_pkg::*;

    localparam int DEPTH = SCALE * SCALE;
    localparam int IDX_W = $clog2(DEPTH);

    seq_state_t state_q, state_d;

    logic [PIX_W-1:0] grp_ul, grp_ur, grp_ll, grp_lr;
    logic [WGT_W-1:0] grp_fx, grp_fy;
    logic             grp_stb;
    logic [1:0]       beat_cnt;
    logic [IDX_W-1:0] wptr;

    logic [PIX_W-1:0] op_ul, op_ur, op_ll, op_lr;
    logic [WGT_W-1:0] fx_q, fy_q;
    logic [ROW_W-1:0] top_r, top_g, top_b;
    logic [ROW_W-1:0] bot_r, bot_g, bot_b;
    logic [CH_W-1:0]  res_r, res_g, res_b;

    logic [1:0]       ch_sel;
    logic [CH_W-1:0]  row_a [2];
    logic [CH_W-1:0]  row_b [2];
    logic [ROW_W-1:0] row_y [2];
    logic [ROW_W-1:0] col_a, col_b;
    logic [COL_W-1:0] col_y;

    function automatic logic [CH_W-1:0] chan(input logic [PIX_W-1:0] p, input logic [1:0] s);
        case (s)
            2'd2:    chan = p[23:16];
            2'd1:    chan = p[15:8];
            default: chan = p[7:0];
        endcase
    endfunction

    bli_gather #(.SCALE(SCALE), .PIX_W(PIX_W), .WGT_W(WGT_W)) gather_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_en  (beat_en),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_pix   (in_pix),
        .grp_ul   (grp_ul),
        .grp_ur   (grp_ur),
        .grp_ll   (grp_ll),
        .grp_lr   (grp_lr),
        .grp_fx   (grp_fx),
        .grp_fy   (grp_fy),
        .grp_stb  (grp_stb),
        .beat_cnt (beat_cnt),
        .wptr     (wptr)
    );

    // channel chosen by the current row or column state
    always_comb begin
        unique case (state_q)
            ST_ROW_R, ST_COL_R: ch_sel = 2'd2;
            ST_ROW_G, ST_COL_G: ch_sel = 2'd1;
            default:            ch_sel = 2'd0;
        endcase
    end

    always_comb begin
        row_a[0] = chan(op_ul, ch_sel);
        row_b[0] = chan(op_ur, ch_sel);
        row_a[1] = chan(op_ll, ch_sel);
        row_b[1] = chan(op_lr, ch_sel);
        unique case (ch_sel)
            2'd2: begin col_a = top_r; col_b = bot_r; end
            2'd1: begin col_a = top_g; col_b = bot_g; end
            default: begin col_a = top_b; col_b = bot_b; end
        endcase
    end

    for (genvar rr = 0; rr < 2; rr++) begin : g_row
        bli_lerp #(.IN_W(CH_W), .F_W(WGT_W)) row_i (
            .a (row_a[rr]),
            .b (row_b[rr]),
            .f (fx_q),
            .y (row_y[rr])
        );
    end

    bli_lerp #(.IN_W(ROW_W), .F_W(WGT_W)) col_i (
        .a (col_a),
        .b (col_b),
        .f (fy_q),
        .y (col_y)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grp_stb) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_ROW_R;
            ST_ROW_R: state_d = ST_ROW_G;
            ST_ROW_G: state_d = ST_ROW_B;
            ST_ROW_B: state_d = ST_COL_R;
            ST_COL_R: state_d = ST_COL_G;
            ST_COL_G: state_d = ST_COL_B;
            ST_COL_B: state_d = ST_PACK;
            ST_PACK:  state_d = grp_stb ? ST_LOAD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_ul <= '0; op_ur <= '0; op_ll <= '0; op_lr <= '0;
            fx_q  <= '0; fy_q  <= '0;
            top_r <= '0; top_g <= '0; top_b <= '0;
            bot_r <= '0; bot_g <= '0; bot_b <= '0;
            res_r <= '0; res_g <= '0; res_b <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_LOAD: begin
                    op_ul <= grp_ul; op_ur <= grp_ur;
                    op_ll <= grp_ll; op_lr <= grp_lr;
                    fx_q  <= grp_fx; fy_q  <= grp_fy;
                end
                ST_ROW_R: begin top_r <= row_y[0]; bot_r <= row_y[1]; end
                ST_ROW_G: begin top_g <= row_y[0]; bot_g <= row_y[1]; end
                ST_ROW_B: begin top_b <= row_y[0]; bot_b <= row_y[1]; end
                ST_COL_R: res_r <= col_y[COL_W-1 -: CH_W];
                ST_COL_G: res_g <= col_y[COL_W-1 -: CH_W];
                ST_COL_B: res_b <= col_y[COL_W-1 -: CH_W];
                ST_PACK: begin
                    out_pix   <= {res_r, res_g, res_b};
                    out_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bli_interp_chk.sv
module bli_interp_chk #(
    parameter int IDX_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                beat_en,
    input logic                in_valid,
    input logic                in_sof,
    input logic                out_valid,
    input logic [23:0]         out_pix,
    input bli_pkg::seq_state_t state,
    input logic [1:0]          beat_cnt,
    input logic [IDX_W-1:0]    wptr,
    input logic                grp_stb
);
    logic [3:0] gap_cnt;
    logic       seen_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            seen_out <= 1'b0;
        end else if (out_valid) begin
            gap_cnt  <= '0;
            seen_out <= 1'b1;
        end else if (gap_cnt != 4'hF) begin
            gap_cnt <= gap_cnt + 4'd1;
        end
    end

    AST_OUT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R8

    AST_OUT_FROM_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state == bli_pkg::ST_PACK)); // R8

    AST_PIX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_pix)); // R10

    AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_en && in_valid && in_sof) |=> (beat_cnt == 2'd1 && wptr == '0)); // R7

    AST_IGNORED_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_en && in_valid) |=> ($stable(beat_cnt) && $stable(wptr))); // R2

    AST_GROUP_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
        grp_stb |-> (state == bli_pkg::ST_IDLE || state == bli_pkg::ST_PACK)); // R9

    AST_OUT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_out) |-> (gap_cnt >= 4'd7)); // R9
endmodule

bind bli_interp bli_interp_chk #(.IDX_W($clog2(SCALE * SCALE))) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_en   (beat_en),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .state     (state_q),
    .beat_cnt  (beat_cnt),
    .wptr      (wptr),
    .grp_stb   (grp_stb)
);

// File: tb/bli_interp_tb_top.sv
`timescale 1ns/1ps
module bli_interp_tb_top;
    localparam int S = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_en = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic [23:0] out_pix;

    always #2.5 clk = ~clk;

    bli_interp #(.SCALE(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .beat_en(beat_en), .in_valid(in_valid),
        .in_sof(in_sof), .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    typedef struct { int due; logic [23:0] pix; } exp_t;
    exp_t exp_q[$];

    int          n_edges = 0;
    int          vectors = 0;
    int          misses = 0;
    bit          running = 1'b0;
    bit          done = 1'b0;
    string       cur_req = "R5";
    logic [23:0] last_pix = '0;

    int          m_cnt = 0;
    int          m_ptr = 0;
    logic [23:0] m_hold [4];

    always @(posedge clk) n_edges <= n_edges + 1;

    function automatic int blend(int ul, int ur, int ll, int lr, int fx, int fy);
        int t, b;
        t = ul * (256 - fx) + ur * fx;
        b = ll * (256 - fx) + lr * fx;
        return (t * (256 - fy) + b * fy) >> 16;
    endfunction

    function automatic logic [23:0] expect_pix(logic [23:0] ul, logic [23:0] ur,
                                               logic [23:0] ll, logic [23:0] lr, int k);
        int fx, fy;
        logic [23:0] r;
        fx = ((k % S) * 256) / S;
        fy = ((k / S) * 256) / S;
        for (int c = 0; c < 3; c++)
            r[c*8 +: 8] = 8'(blend(ul[c*8 +: 8], ur[c*8 +: 8], ll[c*8 +: 8], lr[c*8 +: 8], fx, fy));
        return r;
    endfunction

    // behavioural model of one taken beat whose capture edge is the next posedge
    task automatic model_take(logic [23:0] pix, bit sof);
        exp_t e;
        if (sof) begin
            m_hold[0] = pix; m_cnt = 1; m_ptr = 0;
        end else if (m_cnt == 3) begin
            e.due = n_edges + 10;
            e.pix = expect_pix(m_hold[0], m_hold[1], m_hold[2], pix, m_ptr);
            exp_q.push_back(e);
            m_ptr = (m_ptr + 1) % (S * S);
            m_cnt = 0;
        end else begin
            m_hold[m_cnt] = pix; m_cnt++;
        end
    endtask

    // one beat: strobe cycle, then a junk cycle with beat_en low (R2)
    task automatic beat(bit v, logic [23:0] pix, bit sof);
        @(negedge clk);
        beat_en = 1'b1; in_valid = v; in_pix = pix; in_sof = sof;
        if (v) model_take(pix, sof);
        @(negedge clk);
        beat_en = 1'b0; in_valid = 1'b1; in_pix = 24'($urandom); in_sof = 1'($urandom);
    endtask

    task automatic group(logic [23:0] a, logic [23:0] b, logic [23:0] c, logic [23:0] d, bit sof);
        beat(1'b1, a, sof); beat(1'b1, b, 1'b0); beat(1'b1, c, 1'b0); beat(1'b1, d, 1'b0);
    endtask

    task automatic idle(int beats);
        for (int i = 0; i < beats; i++) beat(1'b0, 24'($urandom), 1'($urandom));
    endtask

    // per-clock comparison against the reference queue
    always @(negedge clk) begin
        if (running && rst_n) begin
            bit ev;
            ev = (exp_q.size() > 0) && (exp_q[0].due == n_edges);
            vectors++;
            if (out_valid !== ev) begin
                misses++;
                $display("FAIL R8 (%s) out_valid actual %b expected %b at edge %0d",
                         cur_req, out_valid, ev, n_edges);
            end else if (ev && out_pix !== exp_q[0].pix) begin
                misses++;
                $display("FAIL %s out_pix actual %h expected %h", cur_req, out_pix, exp_q[0].pix);
            end else if (!ev && out_pix !== last_pix) begin
                misses++;
                $display("FAIL R10 out_pix actual %h expected %h", out_pix, last_pix);
            end
            if (ev) begin
                last_pix = exp_q[0].pix;
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_pix !== 24'h0) begin
            misses++;
            $display("FAIL R1 reset outputs actual %b/%h expected 0/000000", out_valid, out_pix);
        end
        rst_n = 1'b1;
        running = 1'b1;

        // R4 R5: distinct channels, weights entry 0 then 1
        cur_req = "R4";
        group(24'h10_80_F0, 24'h20_40_00, 24'h30_C0_FF, 24'h40_00_7F, 1'b1);
        group(24'hFF_00_80, 24'h00_FF_40, 24'h80_80_80, 24'h01_02_03, 1'b0);
        cur_req = "R11";
        idle(12);

        // R3 R6 R9: back-to-back run wrapping the table
        cur_req = "R6";
        for (int g = 0; g < S * S + 3; g++)
            group(24'($urandom), 24'($urandom), 24'($urandom), 24'($urandom), g == 0);
        cur_req = "R3";
        group(24'hFFFFFF, 24'h000000, 24'h000000, 24'h000000, 1'b1);
        group(24'h000000, 24'hFFFFFF, 24'h000000, 24'h000000, 1'b0);
        group(24'h000000, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b0);
        group(24'h000000, 24'h000000, 24'h000000, 24'hFFFFFF, 1'b0);
        group(24'h000000, 24'h000000, 24'hFFFFFF, 24'hFFFFFF, 1'b0);
        idle(10);

        // R7: start of frame in the middle of a group
        cur_req = "R7";
        group(24'h111111, 24'h222222, 24'h333333, 24'h444444, 1'b1);
        beat(1'b1, 24'hABCDEF, 1'b0);
        beat(1'b1, 24'h123456, 1'b0);
        group(24'h0A0B0C, 24'hF0E0D0, 24'h556677, 24'h998877, 1'b1);
        idle(10);

        // R2: gaps with in_valid low on strobe cycles
        cur_req = "R2";
        beat(1'b1, 24'h808080, 1'b1);
        idle(3);
        beat(1'b1, 24'h202020, 1'b0);
        beat(1'b0, 24'hFFFFFF, 1'b1);
        beat(1'b1, 24'hE0E0E0, 1'b0);
        idle(2);
        beat(1'b1, 24'h606060, 1'b0);
        idle(10);

        // R5 extremes
        cur_req = "R5";
        for (int g = 0; g < 6; g++)
            group(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, g == 0);
        group(24'h000000, 24'h000000, 24'h000000, 24'h000000, 1'b0);
        cur_req = "R11";
        idle(20);

        vectors++;
        if (exp_q.size() != 0) begin
            misses++;
            $display("FAIL R11 pending outputs actual %0d expected 0", exp_q.size());
        end
        running = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule